// File: doc/BRIEF.md
# Prime-Modulus Stepping Address Generator

This block produces the row-by-row pointer sequence for one square permutation sub-matrix of a structured low-density parity-check matrix. It does not store a pointer table. Each address is obtained from the previous one by adding a programmable step and reducing modulo a prime modulus. Because the modulus is prime, any step in the range 1 to modulus-1 walks through every address from 0 to modulus-1 exactly once per pass.

A configuration is taken in by a single load strobe. The configuration is the modulus, the step, and the first address. In the usual setting the first address equals the step. For a cloned copy of a sub-matrix column, the step is kept and the first address is set to the block-row index instead. After the load, each advance cycle moves the sequence one position. A flag marks the final address of each full pass. An invalid configuration is refused and an error flag is raised. The step values are chosen offline and arrive as plain register values.

Top module: `perm_addr_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, `valid`, `done` and `cfg_err` are 0 and `addr` is 0.
- R2: A `load` with an accepted configuration has this effect one cycle later: `addr` equals `init_val`, `valid` is 1, `done` is 0 and `cfg_err` is 0.
- R3: An `advance` while `valid` is 1 (and `load` is 0) sets `addr` one cycle later to (previous `addr` + step) mod modulus. The step and modulus used are the ones latched at the last load.
- R4: A cycle with neither `load` nor `advance` leaves `addr`, `valid` and `done` unchanged.
- R5: `done` is 1 exactly while the presented address is the N-th of the current pass, that is, after N-1 advances since the load. The N addresses of one pass are all distinct.
- R6: An advance taken while `done` is 1 returns `addr` to the first address of the pass, clears `done` and begins a new pass of N addresses.
- R7: A configuration is refused at load when step = 0, step >= modulus, or first address >= modulus. One cycle later `cfg_err` is 1, `valid` is 0, `done` is 0 and `addr` is 0. Advances are then ignored until the next load.
- R8: When `load` and `advance` are both 1 in the same cycle, the load takes effect and the advance is dropped.
- R9: While `valid` is 1, `addr` is below the latched modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Latch modulus, step and first address; start a new pass |
| advance | input | 1 | Move to the next address of the sequence |
| size_n | input | 12 | Prime modulus N (sub-matrix size) |
| root | input | 12 | Step added per advance |
| init_val | input | 12 | First address of the sequence |
| addr | output | 12 | Current pointer |
| valid | output | 1 | A sequence is loaded and `addr` is meaningful |
| done | output | 1 | `addr` is the last address of the current pass |
| cfg_err | output | 1 | The last load was refused |

## Verification
The following are checked on every cycle by the assertions:
- the one-step modular recurrence,
- holding of the state when the block is idle,
- the load result for accepted and refused settings,
- the address range bound,
- the exclusion between `valid` and `cfg_err`.

Other properties can only be shown by the bench scenarios. These are the pass length, measured by when `done` appears, the distinctness of every address in a full pass, the return to the first address after wrapping, and the cloned-column setting where the first address is a row index rather than the step.

// File: rtl/perm_addr_pkg.sv
package perm_addr_pkg;

    localparam int ADDR_W = 12;
    localparam int SUM_W  = ADDR_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SUM_W-1:0]  sum_t;

    typedef struct packed {
        addr_t modulus;
        addr_t step;
    } seq_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FAIL = 2'b10
    } seq_state_e;

    // one reduction step: operands are assumed below the modulus
    function automatic addr_t mod_step(addr_t cur, addr_t step, addr_t modulus);
        sum_t s;
        sum_t m;
        s = {1'b0, cur} + {1'b0, step};
        m = {1'b0, modulus};
        if (s >= m) begin
            s = s - m;
        end
        return s[ADDR_W-1:0];
    endfunction

    function automatic logic cfg_is_good(addr_t modulus, addr_t step, addr_t first);
        return (step != '0) && (step < modulus) && (first < modulus);
    endfunction

endpackage

// File: rtl/pag_cfg_check.sv
module pag_cfg_check
    import perm_addr_pkg::*;
(
    input  addr_t modulus,
    input  addr_t step,
    input  addr_t first,
    output logic  good
);
    always_comb begin
        good = cfg_is_good(modulus, step, first);
    end
endmodule

// File: rtl/pag_mod_step.sv
module pag_mod_step
    import perm_addr_pkg::*;
(
    input  addr_t cur,
    input  addr_t step,
    input  addr_t modulus,
    output addr_t nxt
);
    always_comb begin
        nxt = mod_step(cur, step, modulus);
    end
endmodule

// File: rtl/pag_seq_ctrl.sv
module pag_seq_ctrl
    import perm_addr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     advance,
    input  logic     cfg_good,
    input  addr_t    size_n,
    input  addr_t    root,
    input  addr_t    init_val,
    input  addr_t    step_addr,
    output addr_t    addr,
    output logic     valid,
    output logic     done,
    output logic     cfg_err,
    output seq_cfg_t cfg_q
);
    seq_state_e state_q;
    addr_t      addr_q;
    addr_t      pos_q;   // ordinal of presented address within the pass, 1..N
    logic       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            pos_q   <= '0;
            done_q  <= 1'b0;
            cfg_q   <= '0;
        end else if (load) begin
            done_q <= 1'b0;
            if (cfg_good) begin
                state_q       <= ST_RUN;
                addr_q        <= init_val;
                pos_q         <= addr_t'(1);
                cfg_q.modulus <= size_n;
                cfg_q.step    <= root;
            end else begin
                state_q <= ST_FAIL;
                addr_q  <= '0;
                pos_q   <= '0;
            end
        end else if (advance && state_q == ST_RUN) begin
            addr_q <= step_addr;
            if (pos_q == cfg_q.modulus) begin
                pos_q  <= addr_t'(1);
                done_q <= 1'b0;
            end else begin
                pos_q  <= pos_q + addr_t'(1);
                done_q <= (pos_q + addr_t'(1)) == cfg_q.modulus;
            end
        end
    end

    assign addr    = addr_q;
    assign valid   = (state_q == ST_RUN);
    assign done    = done_q;
    assign cfg_err = (state_q == ST_FAIL);
endmodule

// File: rtl/perm_addr_gen.sv
module perm_addr_gen
    import perm_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] size_n,
    input  logic [ADDR_W-1:0] root,
    input  logic [ADDR_W-1:0] init_val,
    output logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic              done,
    output logic              cfg_err
);
    logic     cfg_good;
    addr_t    step_addr;
    seq_cfg_t cfg_q;
    addr_t    cur_mod;
    addr_t    cur_step;

    pag_cfg_check u_check (
        .modulus (size_n),
        .step    (root),
        .first   (init_val),
        .good    (cfg_good)
    );

    pag_mod_step u_step (
        .cur     (addr),
        .step    (cur_step),
        .modulus (cur_mod),
        .nxt     (step_addr)
    );

    pag_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .advance   (advance),
        .cfg_good  (cfg_good),
        .size_n    (size_n),
        .root      (root),
        .init_val  (init_val),
        .step_addr (step_addr),
        .addr      (addr),
        .valid     (valid),
        .done      (done),
        .cfg_err   (cfg_err),
        .cfg_q     (cfg_q)
    );

    assign cur_mod  = cfg_q.modulus;
    assign cur_step = cfg_q.step;
endmodule

// File: rtl/perm_addr_gen_chk.sv
module perm_addr_gen_chk
    import perm_addr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  load,
    input logic  advance,
    input addr_t size_n,
    input addr_t root,
    input addr_t init_val,
    input addr_t addr,
    input logic  valid,
    input logic  done,
    input logic  cfg_err,
    input addr_t n_q,
    input addr_t root_q
);
    assert_reset_R1: assert property (@(posedge clk) rst |=> (!valid && !done && !cfg_err && addr == '0));

    assert_load_ok_R2: assert property (@(posedge clk) disable iff (rst)
        (load && root != '0 && root < size_n && init_val < size_n)
        |=> (valid && !cfg_err && !done && addr == $past(init_val)));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && advance && !load)
        |=> (addr == (({1'b0, $past(addr)} + {1'b0, $past(root_q)} >= {1'b0, $past(n_q)})
                      ? addr_t'({1'b0, $past(addr)} + {1'b0, $past(root_q)} - {1'b0, $past(n_q)})
                      : addr_t'({1'b0, $past(addr)} + {1'b0, $past(root_q)}))));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> ($stable(addr) && $stable(valid) && $stable(done)));

    assert_done_valid_R5: assert property (@(posedge clk) disable iff (rst) done |-> valid);

    assert_load_bad_R7: assert property (@(posedge clk) disable iff (rst)
        (load && (root == '0 || root >= size_n || init_val >= size_n))
        |=> (cfg_err && !valid && !done && addr == '0));

    assert_excl_R7: assert property (@(posedge clk) disable iff (rst) !(valid && cfg_err));

    assert_range_R9: assert property (@(posedge clk) disable iff (rst) valid |-> (addr < n_q));
endmodule

bind perm_addr_gen perm_addr_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .advance  (advance),
    .size_n   (size_n),
    .root     (root),
    .init_val (init_val),
    .addr     (addr),
    .valid    (valid),
    .done     (done),
    .cfg_err  (cfg_err),
    .n_q      (cur_mod),
    .root_q   (cur_step)
);

// File: tb/perm_addr_gen_tb.sv
module perm_addr_gen_tb;
    import perm_addr_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  load = 1'b0;
    logic  advance = 1'b0;
    addr_t size_n = '0;
    addr_t root = '0;
    addr_t init_val = '0;
    addr_t addr;
    logic  valid, done, cfg_err;

    int checks = 0;
    int fails  = 0;

    // bench model of the requirements
    int m_addr = 0, m_n = 0, m_step = 0, m_pos = 0;
    bit m_valid = 0, m_done = 0, m_err = 0;

    bit seen [0:4095];

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_addr_gen u_dut (
        .clk(clk), .rst(rst), .load(load), .advance(advance),
        .size_n(size_n), .root(root), .init_val(init_val),
        .addr(addr), .valid(valid), .done(done), .cfg_err(cfg_err)
    );

    function automatic bit good_cfg(int n, int r, int i);
        return (r != 0) && (r < n) && (i < n);
    endfunction

    task automatic check(string tag);
        checks++;
        if (addr !== addr_t'(m_addr) || valid !== m_valid || done !== m_done || cfg_err !== m_err) begin
            fails++;
            $display("FAIL %s: addr=%0d valid=%0b done=%0b err=%0b expected addr=%0d valid=%0b done=%0b err=%0b",
                     tag, addr, valid, done, cfg_err, m_addr, m_valid, m_done, m_err);
        end
    endtask

    task automatic cyc(bit ld, bit adv, int n, int r, int i, string tag);
        @(negedge clk);
        load = ld; advance = adv;
        size_n = addr_t'(n); root = addr_t'(r); init_val = addr_t'(i);
        @(posedge clk);
        if (ld) begin
            m_done = 0;
            if (good_cfg(n, r, i)) begin
                m_valid = 1; m_err = 0; m_addr = i; m_pos = 1; m_n = n; m_step = r;
            end else begin
                m_valid = 0; m_err = 1; m_addr = 0; m_pos = 0;
            end
        end else if (adv && m_valid) begin
            m_addr = (m_addr + m_step) % m_n;
            if (m_pos == m_n) begin
                m_pos = 1; m_done = 0;
            end else begin
                m_pos++; m_done = (m_pos == m_n);
            end
        end
        #1;
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int primes [10] = '{2, 3, 5, 7, 11, 13, 31, 41, 127, 4093};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1; check("R1 in reset");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1; check("R1 after reset");

        // R2 usual setting: first address = step
        cyc(1, 0, 7, 3, 3, "R2 load");
        // R4 idle cycles
        cyc(0, 0, 0, 0, 0, "R4 hold");
        cyc(0, 0, 0, 0, 0, "R4 hold");
        // R5 full pass with distinctness over N=41
        cyc(1, 0, 41, 5, 5, "R2 load 41");
        foreach (seen[k]) seen[k] = 0;
        for (int k = 0; k < 41; k++) begin
            checks++;
            if (seen[addr]) begin
                fails++;
                $display("FAIL R5: addr=%0d repeated expected=distinct", addr);
            end
            seen[addr] = 1;
            checks++;
            if (done !== (k == 40)) begin
                fails++;
                $display("FAIL R5: done=%0b expected=%0b at step %0d", done, (k == 40), k);
            end
            if (k < 40) cyc(0, 1, 0, 0, 0, "R3 step");
        end
        // R6 wrap back to the first address
        cyc(0, 1, 0, 0, 0, "R6 wrap");
        checks++;
        if (addr !== addr_t'(5)) begin
            fails++;
            $display("FAIL R6: addr=%0d expected=5", addr);
        end
        // cloned column: same step, first address = row index
        cyc(1, 0, 7, 3, 2, "R2 cloned load");
        for (int k = 0; k < 8; k++) cyc(0, 1, 0, 0, 0, "R5 cloned pass");
        // R7 refused settings
        cyc(1, 0, 7, 0, 1, "R7 step zero");
        cyc(0, 1, 0, 0, 0, "R7 advance ignored");
        cyc(1, 0, 7, 7, 1, "R7 step equals N");
        cyc(1, 0, 7, 2, 7, "R7 first equals N");
        cyc(0, 1, 0, 0, 0, "R7 advance ignored");
        // R8 load wins over advance
        cyc(1, 0, 11, 4, 4, "R2 load 11");
        cyc(0, 1, 0, 0, 0, "R3 step");
        cyc(1, 1, 13, 6, 0, "R8 load priority");
        checks++;
        if (addr !== addr_t'(0)) begin
            fails++;
            $display("FAIL R8: addr=%0d expected=0", addr);
        end
        // N=2 smallest prime
        cyc(1, 0, 2, 1, 1, "R2 load 2");
        cyc(0, 1, 0, 0, 0, "R5 N2 done");
        cyc(0, 1, 0, 0, 0, "R6 N2 wrap");
        // large modulus near the width limit
        cyc(1, 0, 4093, 4092, 4092, "R2 load 4093");
        for (int k = 0; k < 20; k++) cyc(0, 1, 0, 0, 0, "R9 large step");

        // constrained random mix
        for (int t = 0; t < 3000; t++) begin
            int sel;
            sel = int'($urandom_range(0, 99));
            if (sel < 6) begin
                int n, r, i;
                n = primes[$urandom_range(0, 9)];
                r = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, n + 1)) : int'($urandom_range(1, n - 1));
                i = ($urandom_range(0, 15) == 0) ? n : int'($urandom_range(0, n - 1));
                cyc(1, $urandom_range(0, 1) == 1, n, r, i, "R2 R7 R8 random load");
            end else if (sel < 80) begin
                cyc(0, 1, 0, 0, 0, "R3 R5 R6 R9 random advance");
            end else begin
                cyc(0, 0, 0, 0, 0, "R4 random idle");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule